// File: doc/BRIEF.md
# Reconfigurable Array Section Crossbar

This block is the interconnect of a small coarse-grain reconfigurable array. The already-registered outputs of the functional units are packed into one wide bus of 32-bit sections. Each dual-port embedded memory supplies two sections, one per port. Every consumer input of the array has a selector register. That register names the section the input receives, and the chosen word is delivered through a combinational multiplexer. A value therefore reaches its consumer in the same cycle in which its producer registers it.

The selectors sit in two banks. A host processor writes and reads a shadow bank. A single commit strobe copies the whole shadow bank into the active bank in one cycle, so the datapath never runs on a half-loaded configuration. Two stored-configuration slots allow the host to save the active bank and later restore a slot into the shadow bank. With the default sizes there are 4 memories and 11 single-output units, giving 19 sections, 5-bit selectors and 6 consumer inputs.

Top module: `xbar_fabric`

## Requirements
- R1: Section order on the bus: section 2k is port A of memory k, section 2k+1 is port B of memory k, and section 2·NUM_MEM+j is functional unit j (sections 8..18 with the defaults).
- R2: Consumer input i (bits i·32 +: 32 of `operand`) carries the section named by active selector i, combinationally in the same cycle as the bus value.
- R3: An active selector of NUM_SECT (19) or above drives 32'h0 to its input.
- R4: A host write (`cfg_we`, entry `cfg_addr`, value `cfg_wdata`) changes only the shadow bank, and the operands do not change until a commit.
- R5: A `cfg_commit` pulse copies every shadow entry into the active bank at that clock edge, so the new routing is visible in the next cycle.
- R6: A `cfg_save` pulse copies the whole active bank into slot `cfg_slot` (0 or 1).
- R7: A `cfg_restore` pulse copies slot `cfg_slot` into the shadow bank and leaves the active bank unchanged. In the same cycle it overrides a host write.
- R8: With `cfg_re` high at one edge, `cfg_rdata` shows shadow entry `cfg_addr` from that edge onward, one cycle of latency. A read in the cycle of a write to the same entry returns the old value.
- R9: Addresses at or above NUM_IN (6 and 7) are ignored by writes and read back as 0.
- R10: Synchronous active-high reset clears all shadow, active and slot selectors and `cfg_rdata` to 0, so every input routes section 0.
- R11: Without a commit the active bank holds its value, even across saves, restores and host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_port_a | input | 128 | Port A word of each memory, memory k at bits k·32 |
| mem_port_b | input | 128 | Port B word of each memory, memory k at bits k·32 |
| fu_out | input | 352 | Registered output of each functional unit, unit j at bits j·32 |
| cfg_we | input | 1 | Host write strobe into the shadow bank |
| cfg_re | input | 1 | Host read strobe |
| cfg_addr | input | 3 | Selector entry addressed by the host |
| cfg_wdata | input | 5 | Selector value to write |
| cfg_rdata | output | 5 | Registered read data from the shadow bank |
| cfg_commit | input | 1 | Copy shadow bank into active bank |
| cfg_save | input | 1 | Copy active bank into a slot |
| cfg_restore | input | 1 | Copy a slot into the shadow bank |
| cfg_slot | input | 1 | Slot used by save or restore |
| operand | output | 192 | Selected word for each consumer input, input i at bits i·32 |

## Verification
The operands follow bus changes with no delay, so those checks sample one time step after new producer data are applied. Host writes, commits, saves and restores each take effect at the single edge on which their strobe is high. Read data appears at that same edge, so it is due one cycle after the strobe is raised. The bench raises every strobe just after a falling edge, lowers it on the next falling edge and samples there, which is half a cycle after the register that holds the result has loaded. Ignored writes and bank isolation are checked by reading back every entry and comparing every operand after the stimulus.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_WORD_W = 32;

  // Width of an index for n items, at least one bit.
  function automatic int xb_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bank-level commands, bundled for the configuration store.
  typedef struct packed {
    logic commit;
    logic save;
    logic restore;
  } bank_cmd_t;
endpackage

// File: rtl/xbar_bus_pack.sv
module xbar_bus_pack #(
  parameter int WORD_W   = 32,
  parameter int NUM_MEM  = 4,
  parameter int NUM_FU   = 11,
  localparam int NUM_SECT = 2 * NUM_MEM + NUM_FU
) (
  input  logic [NUM_MEM*WORD_W-1:0]            mem_a,
  input  logic [NUM_MEM*WORD_W-1:0]            mem_b,
  input  logic [NUM_FU*WORD_W-1:0]             fu,
  output logic [NUM_SECT-1:0][WORD_W-1:0]      bus
);
  // Memory ports come first, interleaved A/B per memory.
  for (genvar k = 0; k < NUM_MEM; k++) begin : g_mem
    assign bus[2*k]   = mem_a[k*WORD_W +: WORD_W];
    assign bus[2*k+1] = mem_b[k*WORD_W +: WORD_W];
  end
  // Single-output units follow the memory sections.
  for (genvar j = 0; j < NUM_FU; j++) begin : g_fu
    assign bus[2*NUM_MEM+j] = fu[j*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/xbar_sel_mux.sv
module xbar_sel_mux #(
  parameter int WORD_W   = 32,
  parameter int NUM_SECT = 19,
  parameter int SEL_W    = 5
) (
  input  logic [NUM_SECT-1:0][WORD_W-1:0] bus,
  input  logic [SEL_W-1:0]                sel,
  output logic [WORD_W-1:0]               dout
);
  // Unmatched selector codes leave the output at zero.
  always_comb begin
    dout = '0;
    for (int s = 0; s < NUM_SECT; s++) begin
      if (sel == SEL_W'(s)) dout = bus[s];
    end
  end
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
  import xbar_pkg::*;
#(
  parameter int NUM_IN   = 6,
  parameter int SEL_W    = 5,
  parameter int ADDR_W   = 3,
  parameter int NUM_SLOT = 2,
  parameter int SLOT_W   = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          re,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [SEL_W-1:0]              wdata,
  output logic [SEL_W-1:0]              rdata,
  input  bank_cmd_t                     cmd,
  input  logic [SLOT_W-1:0]             slot,
  output logic [NUM_IN-1:0][SEL_W-1:0]  active_sel
);
  typedef logic [NUM_IN-1:0][SEL_W-1:0] bank_t;

  bank_t                 shadow_q;
  bank_t                 active_q;
  bank_t [NUM_SLOT-1:0]  slot_q;

  logic [NUM_IN-1:0]     wr_hit;
  logic [NUM_SLOT-1:0]   slot_hit;
  logic [SEL_W-1:0]      rd_val;
  bank_t                 rest_val;
  logic                  rest_ok;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_hit
    assign wr_hit[i] = we && (addr == ADDR_W'(i));
  end
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot_hit
    assign slot_hit[s] = (slot == SLOT_W'(s));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (addr == ADDR_W'(i)) rd_val = shadow_q[i];
    end
  end

  always_comb begin
    rest_val = '0;
    rest_ok  = 1'b0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (slot_hit[s]) begin
        rest_val = slot_q[s];
        rest_ok  = 1'b1;
      end
    end
  end

  // Shadow bank: restore wins over a host write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (cmd.restore && rest_ok) begin
      shadow_q <= rest_val;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (wr_hit[i]) shadow_q[i] <= wdata;
      end
    end
  end

  // Active bank: whole-bank copy on commit only.
  always_ff @(posedge clk) begin
    if (rst)             active_q <= '0;
    else if (cmd.commit) active_q <= shadow_q;
  end

  // Stored-configuration slots.
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                           slot_q[s] <= '0;
      else if (cmd.save && slot_hit[s])  slot_q[s] <= active_q;
    end
  end

  // Host read port, one cycle of latency.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_val;
  end

  assign active_sel = active_q;

  assert_commit_whole_bank_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.commit |=> active_q == $past(shadow_q));
  assert_active_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd.commit |=> $stable(active_q));
  assert_save_slot0_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd.save && slot == '0) |=> slot_q[0] == $past(active_q));
  assert_restore_shadow_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd.restore && rest_ok) |=> shadow_q == $past(rest_val));
  assert_read_entry0_R8: assert property (@(posedge clk) disable iff (rst)
    (re && addr == '0) |=> rdata == $past(shadow_q[0]));
  assert_bad_addr_read_R9: assert property (@(posedge clk) disable iff (rst)
    (re && int'(addr) >= NUM_IN) |=> rdata == '0);
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
  import xbar_pkg::*;
#(
  parameter int WORD_W   = XB_WORD_W,
  parameter int NUM_MEM  = 4,
  parameter int NUM_FU   = 11,
  parameter int NUM_IN   = 6,
  parameter int NUM_SLOT = 2,
  localparam int NUM_SECT = 2 * NUM_MEM + NUM_FU,
  localparam int SEL_W    = xb_bits(NUM_SECT),
  localparam int ADDR_W   = xb_bits(NUM_IN),
  localparam int SLOT_W   = xb_bits(NUM_SLOT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_MEM*WORD_W-1:0]  mem_port_a,
  input  logic [NUM_MEM*WORD_W-1:0]  mem_port_b,
  input  logic [NUM_FU*WORD_W-1:0]   fu_out,
  input  logic                       cfg_we,
  input  logic                       cfg_re,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [SEL_W-1:0]           cfg_wdata,
  output logic [SEL_W-1:0]           cfg_rdata,
  input  logic                       cfg_commit,
  input  logic                       cfg_save,
  input  logic                       cfg_restore,
  input  logic [SLOT_W-1:0]          cfg_slot,
  output logic [NUM_IN*WORD_W-1:0]   operand
);
  logic [NUM_SECT-1:0][WORD_W-1:0] sect_bus;
  logic [NUM_IN-1:0][SEL_W-1:0]    active_sel;
  bank_cmd_t                       cmd;

  assign cmd.commit  = cfg_commit;
  assign cmd.save    = cfg_save;
  assign cmd.restore = cfg_restore;

  xbar_bus_pack #(
    .WORD_W (WORD_W),
    .NUM_MEM(NUM_MEM),
    .NUM_FU (NUM_FU)
  ) u_pack (
    .mem_a(mem_port_a),
    .mem_b(mem_port_b),
    .fu   (fu_out),
    .bus  (sect_bus)
  );

  xbar_cfg_bank #(
    .NUM_IN  (NUM_IN),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W),
    .NUM_SLOT(NUM_SLOT),
    .SLOT_W  (SLOT_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .re        (cfg_re),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .cmd       (cmd),
    .slot      (cfg_slot),
    .active_sel(active_sel)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [WORD_W-1:0] pick;

    xbar_sel_mux #(
      .WORD_W  (WORD_W),
      .NUM_SECT(NUM_SECT),
      .SEL_W   (SEL_W)
    ) u_mux (
      .bus (sect_bus),
      .sel (active_sel[i]),
      .dout(pick)
    );

    assign operand[i*WORD_W +: WORD_W] = pick;

    assert_oob_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (int'(active_sel[i]) >= NUM_SECT) |-> pick == '0);
    assert_fu0_route_R1: assert property (@(posedge clk) disable iff (rst)
      (int'(active_sel[i]) == 2*NUM_MEM) |-> pick == fu_out[WORD_W-1:0]);
    assert_mem0b_route_R2: assert property (@(posedge clk) disable iff (rst)
      (active_sel[i] == SEL_W'(1)) |-> pick == mem_port_b[WORD_W-1:0]);
  end
endmodule

// File: tb/xbar_fabric_bench.sv
module xbar_fabric_bench;
  localparam int W = 32, NM = 4, NF = 11, NI = 6, NS = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM*W-1:0] mem_a, mem_b;
  logic [NF*W-1:0] fu;
  logic cfg_we = 0, cfg_re = 0, cfg_commit = 0, cfg_save = 0, cfg_restore = 0;
  logic [2:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic [0:0] cfg_slot = '0;
  logic [NI*W-1:0] operand;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] pat = 32'h0;
  logic [4:0] exp_shadow [NI];
  logic [4:0] exp_active [NI];

  always #5 clk = ~clk;

  xbar_fabric u_xbar_fabric (
    .clk(clk), .rst(rst), .mem_port_a(mem_a), .mem_port_b(mem_b), .fu_out(fu),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_commit(cfg_commit), .cfg_save(cfg_save),
    .cfg_restore(cfg_restore), .cfg_slot(cfg_slot), .operand(operand)
  );

  // Expected word of a section from the bus order rule (R1, R3).
  function automatic logic [31:0] sect_val(input logic [4:0] s);
    if (s >= NS) return 32'h0;
    if (s < 2*NM) return ((s[0] ? 32'hB000_0000 : 32'hA000_0000) | (32'(s) >> 1)) ^ pat;
    return (32'hC000_0000 | (32'(s) - 32'(2*NM))) ^ pat;
  endfunction

  task automatic apply_data();
    for (int k = 0; k < NM; k++) begin
      mem_a[k*W +: W] = (32'hA000_0000 | 32'(k)) ^ pat;
      mem_b[k*W +: W] = (32'hB000_0000 | 32'(k)) ^ pat;
    end
    for (int j = 0; j < NF; j++) fu[j*W +: W] = (32'hC000_0000 | 32'(j)) ^ pat;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ops(input string req);
    for (int i = 0; i < NI; i++)
      chk(req, operand[i*W +: W], sect_val(exp_active[i]));
  endtask

  task automatic host_write(input logic [2:0] a, input logic [4:0] v);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (a < NI) exp_shadow[a] = v;
  endtask

  task automatic host_read(input logic [2:0] a, input logic [4:0] exp, input string req);
    cfg_re = 1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 0;
    chk(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic do_commit();
    cfg_commit = 1;
    @(negedge clk);
    cfg_commit = 0;
    for (int i = 0; i < NI; i++) exp_active[i] = exp_shadow[i];
  endtask

  task automatic t_reset();
    for (int i = 0; i < NI; i++) begin exp_shadow[i] = 0; exp_active[i] = 0; end
    chk("R10 rdata", 32'(cfg_rdata), 32'h0);
    chk_ops("R10 operands route section 0");
  endtask

  task automatic t_route();
    for (int i = 0; i < NI; i++) host_write(3'(i), 5'(i*3 + 1));
    chk_ops("R4 writes not visible before commit");
    do_commit();
    chk_ops("R5/R1 routing after commit");
    pat = 32'h0F0F_1234; apply_data(); #1;
    chk_ops("R2 same-cycle follow of bus");
    for (int i = 0; i < NI; i++) host_write(3'(i), 5'(18 - i));
    do_commit();
    chk_ops("R1 upper sections incl. 18");
  endtask

  task automatic t_oob();
    host_write(3'd0, 5'd19);
    host_write(3'd3, 5'd31);
    do_commit();
    chk_ops("R3 out-of-range selectors give zero");
  endtask

  task automatic t_read();
    host_read(3'd0, exp_shadow[0], "R8 read entry 0");
    host_read(3'd5, exp_shadow[5], "R8 read entry 5");
    // Read and write to the same entry in one cycle: old value returned.
    cfg_we = 1; cfg_re = 1; cfg_addr = 3'd2; cfg_wdata = 5'd7;
    @(negedge clk);
    cfg_we = 0; cfg_re = 0;
    chk("R8 read-before-write", 32'(cfg_rdata), 32'(exp_shadow[2]));
    exp_shadow[2] = 5'd7;
    host_read(3'd2, 5'd7, "R8 new value after write");
  endtask

  task automatic t_bad_addr();
    host_write(3'd7, 5'd3);
    host_write(3'd6, 5'd4);
    host_read(3'd7, 5'd0, "R9 read addr 7");
    host_read(3'd6, 5'd0, "R9 read addr 6");
    for (int i = 0; i < NI; i++) host_read(3'(i), exp_shadow[i], "R9 entries untouched");
  endtask

  task automatic t_save_restore();
    logic [4:0] saved [NI];
    do_commit();
    for (int i = 0; i < NI; i++) saved[i] = exp_active[i];
    cfg_save = 1; cfg_slot = 1'b1;
    @(negedge clk);
    cfg_save = 0;
    chk_ops("R11 save leaves active bank");
    for (int i = 0; i < NI; i++) host_write(3'(i), 5'(8 + i));
    do_commit();
    chk_ops("R5 second configuration live");
    // Restore slot 1 while writing entry 2: restore must win.
    cfg_restore = 1; cfg_slot = 1'b1; cfg_we = 1; cfg_addr = 3'd2; cfg_wdata = 5'd17;
    @(negedge clk);
    cfg_restore = 0; cfg_we = 0;
    for (int i = 0; i < NI; i++) exp_shadow[i] = saved[i];
    chk_ops("R7/R11 restore does not touch active");
    for (int i = 0; i < NI; i++) host_read(3'(i), exp_shadow[i], "R7 shadow holds restored slot, R6 slot saved");
    do_commit();
    chk_ops("R6 saved routing live again");
    cfg_restore = 1; cfg_slot = 1'b0;
    @(negedge clk);
    cfg_restore = 0;
    for (int i = 0; i < NI; i++) exp_shadow[i] = 5'd0;
    host_read(3'd4, 5'd0, "R7 slot 0 still reset value");
  endtask

  initial begin
    apply_data();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_route();
    t_oob();
    t_read();
    t_bad_addr();
    t_save_restore();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule